// File: doc/BRIEF.md
# XOR-Coded Flit Receive Decoder

This block is the receive side of one router input port whose upstream neighbour never stalls a flit for switch arbitration. When several upstream inputs compete for the same output, the upstream switch drives the bitwise XOR of all of them onto the link. In each following cycle it drops the flit its arbiter granted from the XOR set. The link therefore carries a run of masked words that ends with one plain word. Each masked word is the XOR of the granted flit and of every flit granted after it.

The decoder writes each arriving word, together with its masked/plain flag, into a small circular flit store. It releases flits from the head of the store to the local switch over a valid/ready handshake. A plain head word is released as it is. A masked head word is unmasked by XORing it with the entry stored directly behind it, so the logic only ever looks at two adjacent entries, however many flits collided upstream. Flits leave in the order the upstream arbiter granted them. A credit counter tells the upstream router how many slots are free. A slot is handed back only when its own entry is released, so a plain word that serves as the key for the masked word ahead of it stays stored until it is released itself.

Top module: `xor_flit_rx`

## Requirements
- R1: When the head entry is plain (coded flag 0), `flit_valid` is 1 and `flit_data` equals the stored word unchanged.
- R2: When the head entry is masked (coded flag 1) and a second entry is stored, `flit_valid` is 1 and `flit_data` is the bitwise XOR of the head word and the word stored directly after it.
- R3: While the only stored entry is masked, `flit_valid` stays 0 until the following word has been stored.
- R4: While the store is empty, `flit_valid` is 0.
- R5: Flits are released in the order their words arrived. For a run of N words carrying flits P0..PN-1, word i is the XOR of Pi..PN-1 and is masked except the last. The run yields exactly P0..PN-1 in that order and nothing else.
- R6: `credits` is DEPTH (4) after reset. It drops by one on each cycle a word is stored and rises by one on each cycle a flit is released (`flit_valid` and `flit_ready` both 1), so it always equals DEPTH minus the number of stored entries.
- R7: A word presented with `link_valid` while `credits` is 0 is discarded. It is never released and leaves `credits` unchanged.
- R8: While `flit_valid` is 1 and `flit_ready` is 0, `flit_valid` stays 1 and `flit_data` stays stable in the next cycle.
- R9: In a cycle where a word is stored and a flit is released together, `credits` is unchanged.
- R10: Reset is synchronous and active high. After reset the store is empty, `flit_valid` is 0 and `credits` is DEPTH.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| link_valid | input | 1 | A word is present on the link this cycle |
| link_data | input | DATA_W (64) | Link word, plain or XOR-masked |
| link_coded | input | 1 | 1 = word is masked and needs its successor to unmask |
| credits | output | $clog2(DEPTH+1) (3) | Free slots advertised upstream |
| flit_valid | output | 1 | A plain flit is offered to the local switch |
| flit_data | output | DATA_W (64) | Recovered plain flit |
| flit_ready | input | 1 | Local switch takes the flit this cycle |

## Verification
Several properties are checked on every cycle:
- `flit_valid` drops while the head is a masked word with nothing behind it, and while the store is empty.
- Plain heads pass through unchanged.
- Credits plus stored entries always sum to the depth.
- A simultaneous store and release leaves the credit count unchanged.
- Offered flits hold during back-pressure.

Only the bench's scenarios can show the rest:
- Collision runs of one to four words unmask to the original flits in grant order.
- A masked word waits through idle link cycles for its key.
- A word sent into a full store never shows up at the output.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

    // Default geometry of one input port
    localparam int FLIT_W_DEF    = 64;
    localparam int BUF_DEPTH_DEF = 4;

    // What the entry at the head of the store allows this cycle
    typedef enum logic [1:0] {
        HK_EMPTY    = 2'd0,  // nothing stored
        HK_PLAIN    = 2'd1,  // plain word, release as is
        HK_WAIT_KEY = 2'd2,  // masked word, successor not yet stored
        HK_UNMASK   = 2'd3   // masked word, successor present
    } head_kind_e;

    function automatic head_kind_e classify_head(
        input logic have_head,
        input logic have_next,
        input logic head_coded
    );
        if (!have_head)      return HK_EMPTY;
        else if (!head_coded) return HK_PLAIN;
        else if (!have_next)  return HK_WAIT_KEY;
        else                  return HK_UNMASK;
    endfunction

    function automatic logic kind_releasable(input head_kind_e k);
        return (k == HK_PLAIN) || (k == HK_UNMASK);
    endfunction

endpackage

// File: rtl/xfr_flit_store.sv
module xfr_flit_store #(
    parameter int DATA_W = xfr_pkg::FLIT_W_DEF,
    parameter int DEPTH  = xfr_pkg::BUF_DEPTH_DEF,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_coded,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] head_data,
    output logic              head_coded,
    output logic [DATA_W-1:0] next_data,
    output logic [CNT_W-1:0]  occupancy,
    output logic              full
);

    // DEPTH must be a power of two and at least 2: pointers wrap naturally.
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              coded;
    } slot_t;

    slot_t              slots_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr_q;
    logic [PTR_W-1:0]   rd_ptr_q;
    logic [PTR_W-1:0]   nx_ptr;
    logic [CNT_W-1:0]   count_q;
    logic [DEPTH-1:0]   slot_we;

    // Per-slot write strobes
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_we
        assign slot_we[i] = wr_en && (wr_ptr_q == PTR_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_we[i]) begin
                    slots_q[i] <= '{word: wr_data, coded: wr_coded};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (wr_en)  wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            if (rd_pop) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            case ({wr_en, rd_pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign nx_ptr     = rd_ptr_q + PTR_W'(1);
    assign head_data  = slots_q[rd_ptr_q].word;
    assign head_coded = slots_q[rd_ptr_q].coded;
    assign next_data  = slots_q[nx_ptr].word;
    assign occupancy  = count_q;
    assign full       = (count_q == CNT_W'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !wr_en);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) |-> !rd_pop);

endmodule

// File: rtl/xfr_unmask.sv
module xfr_unmask #(
    parameter int DATA_W = xfr_pkg::FLIT_W_DEF,
    parameter int DEPTH  = xfr_pkg::BUF_DEPTH_DEF,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  occupancy,
    input  logic [DATA_W-1:0] head_data,
    input  logic              head_coded,
    input  logic [DATA_W-1:0] next_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import xfr_pkg::*;

    head_kind_e kind;
    logic       have_head;
    logic       have_next;

    // Two adjacent entries are enough whatever the collision width upstream
    assign have_head = (occupancy != '0);
    assign have_next = (occupancy > CNT_W'(1));
    assign kind      = classify_head(have_head, have_next, head_coded);
    assign out_valid = kind_releasable(kind);
    assign out_data  = (kind == HK_UNMASK) ? (head_data ^ next_data) : head_data;

    // R3
    wait_for_key_chk: assert property (@(posedge clk) disable iff (rst)
        (head_coded && occupancy == CNT_W'(1)) |-> !out_valid);

    // R4
    empty_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (occupancy == '0) |-> !out_valid);

    // R1
    plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !head_coded) |-> (out_data == head_data));

endmodule

// File: rtl/xfr_credit_ctr.sv
module xfr_credit_ctr #(
    parameter int DEPTH  = xfr_pkg::BUF_DEPTH_DEF,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             give,
    output logic [CNT_W-1:0] credits
);

    logic [CNT_W-1:0] credits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            credits_q <= CNT_W'(DEPTH);
        end else begin
            case ({take, give})
                2'b10:   credits_q <= credits_q - CNT_W'(1);
                2'b01:   credits_q <= credits_q + CNT_W'(1);
                default: credits_q <= credits_q;
            endcase
        end
    end

    assign credits = credits_q;

    // R6
    credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        credits_q <= CNT_W'(DEPTH));

    // R9
    credit_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (take && give) |=> $stable(credits_q));

endmodule

// File: rtl/xor_flit_rx.sv
module xor_flit_rx #(
    parameter int DATA_W = xfr_pkg::FLIT_W_DEF,
    parameter int DEPTH  = xfr_pkg::BUF_DEPTH_DEF,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_valid,
    input  logic [DATA_W-1:0] link_data,
    input  logic              link_coded,
    output logic [CNT_W-1:0]  credits,
    output logic              flit_valid,
    output logic [DATA_W-1:0] flit_data,
    input  logic              flit_ready
);

    logic              accept;
    logic              release_now;
    logic              store_full;
    logic [CNT_W-1:0]  occupancy;
    logic [DATA_W-1:0] head_data;
    logic [DATA_W-1:0] next_data;
    logic              head_coded;

    assign accept      = link_valid && !store_full;
    assign release_now = flit_valid && flit_ready;

    xfr_flit_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept),
        .wr_data    (link_data),
        .wr_coded   (link_coded),
        .rd_pop     (release_now),
        .head_data  (head_data),
        .head_coded (head_coded),
        .next_data  (next_data),
        .occupancy  (occupancy),
        .full       (store_full)
    );

    xfr_unmask #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_unmask (
        .clk        (clk),
        .rst        (rst),
        .occupancy  (occupancy),
        .head_data  (head_data),
        .head_coded (head_coded),
        .next_data  (next_data),
        .out_valid  (flit_valid),
        .out_data   (flit_data)
    );

    xfr_credit_ctr #(.DEPTH(DEPTH)) u_credit (
        .clk     (clk),
        .rst     (rst),
        .take    (accept),
        .give    (release_now),
        .credits (credits)
    );

    // R6
    credit_occ_sum_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, credits} + {1'b0, occupancy}) == (CNT_W + 1)'(DEPTH));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data)));

    // R7
    drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (link_valid && credits == '0 && !release_now) |=> $stable(credits));

endmodule

// File: tb/tb_xor_flit_rx.sv
`timescale 1ns/1ps
module tb_xor_flit_rx;

    localparam int W = 64;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         link_valid = 1'b0;
    logic [W-1:0] link_data = '0;
    logic         link_coded = 1'b0;
    logic [2:0]   credits;
    logic         flit_valid;
    logic [W-1:0] flit_data;
    logic         flit_ready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    int ready_mode = 0;         // 0 always ready, 1 alternate, 2 never
    int exp_occ = 0;            // independent model of stored entries
    logic [W-1:0] exp_q[$];
    logic [W-1:0] seed = 64'h1234_5678_9abc_def0;

    xor_flit_rx #(.DATA_W(W), .DEPTH(D)) dut (
        .clk        (clk),
        .rst        (rst),
        .link_valid (link_valid),
        .link_data  (link_data),
        .link_coded (link_coded),
        .credits    (credits),
        .flit_valid (flit_valid),
        .flit_data  (flit_data),
        .flit_ready (flit_ready)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] next_val();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed;
    endfunction

    // Driver: respects credits
    task automatic send_word(input logic [W-1:0] d, input logic c);
        @(negedge clk);
        while (credits == 3'd0) @(negedge clk);
        link_valid = 1'b1;
        link_data  = d;
        link_coded = c;
    endtask

    task automatic idle();
        @(negedge clk);
        link_valid = 1'b0;
        link_coded = 1'b0;
    endtask

    // A collision run of n flits; gap idle cycles after the first word
    task automatic send_group(input int n, input int gap);
        logic [W-1:0] p[4];
        logic [W-1:0] w;
        for (int i = 0; i < n; i++) begin
            p[i] = next_val();
            exp_q.push_back(p[i]);
        end
        for (int i = 0; i < n; i++) begin
            w = '0;
            for (int j = i; j < n; j++) w ^= p[j];
            send_word(w, (i != n - 1));
            if (i == 0 && gap > 0) begin
                idle();
                repeat (gap) @(negedge clk);
            end
        end
        idle();
    endtask

    task automatic wait_drain();
        int guard = 0;
        while ((exp_q.size() != 0 || exp_occ != 0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        #2;
        check(flit_valid == 1'b0, "R4 empty output", W'(flit_valid), '0);
        check(credits == 3'd4, "R6 credits after drain", W'(credits), W'(4));
    endtask

    // Monitor / scoreboard
    initial begin
        logic         hold_pending = 1'b0;
        logic [W-1:0] hold_data = '0;
        logic         both_last = 1'b0;
        logic         push_now;
        logic         pop_now;
        logic [W-1:0] e;
        forever begin
            @(negedge clk);
            case (ready_mode)
                0:       flit_ready = 1'b1;
                1:       flit_ready = ~flit_ready;
                default: flit_ready = 1'b0;
            endcase
            #1;
            if (!rst) begin
                if (hold_pending) begin
                    // R8
                    check(flit_valid && flit_data == hold_data, "R8 hold under stall",
                          flit_data, hold_data);
                end
                hold_pending = flit_valid && !flit_ready;
                hold_data    = flit_data;

                check(credits == 3'(D - exp_occ), both_last ? "R9 swap credits" : "R6 credits",
                      W'(credits), W'(D - exp_occ));

                push_now = link_valid && (exp_occ < D);
                pop_now  = flit_valid && flit_ready;
                if (pop_now) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5/R7 unexpected flit", flit_data, '0);
                    end else begin
                        e = exp_q.pop_front();
                        // R1 R2 R5
                        check(flit_data == e, "R1/R2/R5 flit value", flit_data, e);
                    end
                end
                both_last = push_now && pop_now;
                exp_occ   = exp_occ + int'(push_now) - int'(pop_now);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        // R10
        check(flit_valid == 1'b0, "R10 reset valid", W'(flit_valid), '0);
        check(credits == 3'd4, "R10 reset credits", W'(credits), W'(4));

        // R1 plain words
        ready_mode = 0;
        for (int k = 0; k < 3; k++) send_group(1, 0);
        wait_drain();

        // R2 R5 collision runs of 2, 3, 4
        send_group(2, 0);
        send_group(3, 0);
        send_group(4, 0);
        wait_drain();

        // R3 masked word alone waits for its key
        begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = next_val();
            b = next_val();
            exp_q.push_back(a);
            exp_q.push_back(b);
            send_word(a ^ b, 1'b1);
            idle();
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                #2;
                check(flit_valid == 1'b0, "R3 waiting for key", W'(flit_valid), '0);
            end
            send_word(b, 1'b0);
            idle();
        end
        wait_drain();

        // R8 R9 back-pressure with mixed runs
        ready_mode = 1;
        send_group(3, 0);
        send_group(1, 0);
        send_group(2, 2);
        send_group(4, 0);
        wait_drain();

        // R7 overflow: fill, then offer one more word
        ready_mode = 2;
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] v;
            v = next_val();
            exp_q.push_back(v);
            send_word(v, 1'b0);
        end
        @(negedge clk);
        link_valid = 1'b1;
        link_data  = 64'hDEAD_BEEF_0BAD_F00D;
        link_coded = 1'b0;
        idle();
        #2;
        check(credits == 3'd0, "R7 credits after drop", W'(credits), '0);
        ready_mode = 0;
        wait_drain();

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule